// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the two threshold registers that set how early a FIFO warns that it is nearly empty or nearly full. It turns the FIFO occupancy count into two registered, active-low warning flags. The FIFO storage and its pointers are outside this block; only the occupancy count comes in.

The level of `ld` while master reset is held picks the loading method for everything that follows. With `ld` low, both thresholds start at 127 and software may later write them over the parallel bus. With `ld` high, both thresholds start at 1023 and may only be changed one bit at a time through the serial input. That input is the pin the FIFO uses to choose its mode during reset. The thresholds can be read back over the parallel bus whichever method was chosen. A partial reset clears the flags and the access position but keeps the thresholds and the method.

Top module: `flg_ofs_loader`

## Requirements
- R1: When `mrs_n` is low for at least one rising clock edge with `ld` low, both thresholds become 127 and parallel-write mode is selected.
- R2: When `mrs_n` is low for at least one rising clock edge with `ld` high, both thresholds become 1023 and serial mode is selected. The mode does not change while `mrs_n` is high.
- R3: In parallel mode, `wr_en` stores `wdata` into the register that a shared selector points at. The selector starts at the empty threshold (selector 0) and then points at the full threshold (selector 1), and it toggles on every accepted write or read. `rd_en` loads `rdata` with the selected register one clock later, in either mode.
- R4: In serial mode, each clock with `sen` high stores `si` at the next bit position. Bit positions 0 to 9 are the empty threshold, LSB first, and positions 10 to 19 are the full threshold, LSB first. The position then wraps to 0.
- R5: `wr_en` in serial mode and `sen` in parallel mode have no effect on either threshold.
- R6: While `prs_n` is low at a clock edge, both thresholds and the mode are kept, the selector returns to 0, the serial bit position returns to 0, and write, read and serial requests are ignored.
- R7: `pae_n` is 0 one clock after an edge where `count` is at or below the empty threshold, and 1 otherwise.
- R8: `paf_n` is 0 one clock after an edge where `DEPTH - count` is at or below the full threshold, and 1 otherwise.
- R9: While `mrs_n` is low, and one clock after `prs_n` is low, `pae_n` is 0 and `paf_n` is 1. `rdata` is 0 after master reset.
- R10: When `wr_en` and `rd_en` are both high in parallel mode, only the write takes effect: `rdata` holds and the selector toggles once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrs_n | input | 1 | Master reset, active low, asynchronous assert |
| prs_n | input | 1 | Partial reset, active low, sampled on the clock |
| ld | input | 1 | Loading method select, sampled during master reset |
| si | input | 1 | Serial threshold bit, shared with the FIFO mode pin |
| sen | input | 1 | Serial bit enable |
| wr_en | input | 1 | Parallel threshold write strobe |
| rd_en | input | 1 | Parallel threshold read strobe |
| wdata | input | OFS_W | Parallel threshold write data |
| count | input | CNT_W | FIFO occupancy, 0 to DEPTH |
| pae_n | output | 1 | Almost-empty flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |
| rdata | output | OFS_W | Threshold readback |

## Verification
The properties assume that `count` never exceeds `DEPTH`. Without that assumption the free-space value would wrap and the full-flag relation would no longer hold. They also assume that master reset is held across at least one rising edge, so the thresholds and mode are captured before checking starts. The stimulus draws `count` only from 0 to `DEPTH`, biased toward each threshold and the value one above it. Each master reset is held low for two clock edges, and reset is released away from the active edge.

// File: rtl/flg_ofs_pkg.sv
package flg_ofs_pkg;
  typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} ofs_sel_e;
  typedef enum logic {LOAD_PAR = 1'b0, LOAD_SER = 1'b1} load_mode_e;
endpackage

// File: rtl/flg_ofs_store.sv
module flg_ofs_store
  import flg_ofs_pkg::*;
#(
  parameter int OFS_W    = 10,
  parameter int DFLT_PAR = 127,
  parameter int DFLT_SER = 1023
) (
  input  logic             clk,
  input  logic             mrs_n,
  input  logic             prs_n,
  input  logic             ld,
  input  logic             si,
  input  logic             sen,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] wdata,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs,
  output load_mode_e       ld_mode,
  output logic [OFS_W-1:0] rdata
);
  localparam int NBITS = 2 * OFS_W;
  localparam int IDX_W = $clog2(NBITS);

  ofs_sel_e         sel_q, sel_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [OFS_W-1:0] rdata_q, rdata_d;
  logic [OFS_W-1:0] ae_d, af_d;
  logic             par_wr, par_rd, ser_ld;

  always_comb begin
    par_wr  = prs_n && (ld_mode == LOAD_PAR) && wr_en;
    par_rd  = prs_n && rd_en && !par_wr;
    ser_ld  = prs_n && (ld_mode == LOAD_SER) && sen;
    ae_d    = ae_ofs;
    af_d    = af_ofs;
    rdata_d = rdata_q;
    sel_d   = sel_q;
    idx_d   = idx_q;
    if (!prs_n) begin
      sel_d = SEL_AE;
      idx_d = '0;
    end else begin
      if (par_wr) begin
        if (sel_q == SEL_AE) ae_d = wdata;
        else                 af_d = wdata;
      end
      if (par_rd) rdata_d = (sel_q == SEL_AE) ? ae_ofs : af_ofs;
      if (par_wr || par_rd) sel_d = (sel_q == SEL_AE) ? SEL_AF : SEL_AE;
      if (ser_ld) begin
        for (int b = 0; b < OFS_W; b++) begin
          if (idx_q == IDX_W'(b))         ae_d[b] = si;
          if (idx_q == IDX_W'(b + OFS_W)) af_d[b] = si;
        end
        idx_d = (idx_q == IDX_W'(NBITS - 1)) ? '0 : idx_q + 1'b1;
      end
    end
  end

  // thresholds and mode are captured while master reset is held
  always_ff @(posedge clk) begin
    if (!mrs_n) begin
      ld_mode <= ld ? LOAD_SER : LOAD_PAR;
      ae_ofs  <= ld ? OFS_W'(DFLT_SER) : OFS_W'(DFLT_PAR);
      af_ofs  <= ld ? OFS_W'(DFLT_SER) : OFS_W'(DFLT_PAR);
    end else begin
      ae_ofs  <= ae_d;
      af_ofs  <= af_d;
    end
  end

  always_ff @(posedge clk or negedge mrs_n) begin
    if (!mrs_n) begin
      sel_q   <= SEL_AE;
      idx_q   <= '0;
      rdata_q <= '0;
    end else begin
      sel_q   <= sel_d;
      idx_q   <= idx_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/flg_ofs_flags.sv
module flg_ofs_flags #(
  parameter int OFS_W = 10,
  parameter int DEPTH = 2048,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             mrs_n,
  input  logic             prs_n,
  input  logic [CNT_W-1:0] count,
  input  logic [OFS_W-1:0] ae_ofs,
  input  logic [OFS_W-1:0] af_ofs,
  output logic             pae_n,
  output logic             paf_n
);
  logic [CNT_W-1:0] free_cnt;
  logic             pae_d, paf_d, pae_q, paf_q;

  always_comb begin
    free_cnt = CNT_W'(DEPTH) - count;
    if (!prs_n) begin
      pae_d = 1'b0;
      paf_d = 1'b1;
    end else begin
      pae_d = count > CNT_W'(ae_ofs);
      paf_d = free_cnt > CNT_W'(af_ofs);
    end
  end

  always_ff @(posedge clk or negedge mrs_n) begin
    if (!mrs_n) begin
      pae_q <= 1'b0;
      paf_q <= 1'b1;
    end else begin
      pae_q <= pae_d;
      paf_q <= paf_d;
    end
  end

  assign pae_n = pae_q;
  assign paf_n = paf_q;
endmodule

// File: rtl/flg_ofs_loader.sv
module flg_ofs_loader
  import flg_ofs_pkg::*;
#(
  parameter int OFS_W    = 10,
  parameter int DEPTH    = 2048,
  parameter int DFLT_PAR = 127,
  parameter int DFLT_SER = 1023,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             mrs_n,
  input  logic             prs_n,
  input  logic             ld,
  input  logic             si,
  input  logic             sen,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] wdata,
  input  logic [CNT_W-1:0] count,
  output logic             pae_n,
  output logic             paf_n,
  output logic [OFS_W-1:0] rdata
);
  logic [OFS_W-1:0] ae_ofs, af_ofs;
  load_mode_e       ld_mode;

  flg_ofs_store #(.OFS_W(OFS_W), .DFLT_PAR(DFLT_PAR), .DFLT_SER(DFLT_SER)) u_store (
    .clk(clk), .mrs_n(mrs_n), .prs_n(prs_n), .ld(ld), .si(si), .sen(sen),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .ae_ofs(ae_ofs),
    .af_ofs(af_ofs), .ld_mode(ld_mode), .rdata(rdata)
  );

  flg_ofs_flags #(.OFS_W(OFS_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
    .clk(clk), .mrs_n(mrs_n), .prs_n(prs_n), .count(count),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .pae_n(pae_n), .paf_n(paf_n)
  );
endmodule

// File: rtl/flg_ofs_loader_chk.sv
module flg_ofs_loader_chk
  import flg_ofs_pkg::*;
#(
  parameter int OFS_W = 10,
  parameter int DEPTH = 2048,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             mrs_n,
  input logic             prs_n,
  input logic             sen,
  input logic             wr_en,
  input logic             rd_en,
  input logic [CNT_W-1:0] count,
  input logic [OFS_W-1:0] ae_ofs,
  input logic [OFS_W-1:0] af_ofs,
  input load_mode_e       ld_mode,
  input logic             pae_n,
  input logic             paf_n,
  input logic [OFS_W-1:0] rdata
);
  p_part_flags_r9: assert property (@(posedge clk) disable iff (!mrs_n)
    !prs_n |=> (!pae_n && paf_n));

  p_pae_cmp_r7: assert property (@(posedge clk) disable iff (!mrs_n)
    prs_n |=> (pae_n == ($past(count) > CNT_W'($past(ae_ofs)))));

  p_paf_cmp_r8: assert property (@(posedge clk) disable iff (!mrs_n)
    prs_n |=> (paf_n == ((CNT_W'(DEPTH) - $past(count)) > CNT_W'($past(af_ofs)))));

  p_mode_keep_r2: assert property (@(posedge clk) disable iff (!mrs_n)
    1'b1 |=> $stable(ld_mode));

  p_par_lock_r5: assert property (@(posedge clk) disable iff (!mrs_n)
    (ld_mode == LOAD_PAR && !wr_en) |=> ($stable(ae_ofs) && $stable(af_ofs)));

  p_ser_lock_r5: assert property (@(posedge clk) disable iff (!mrs_n)
    (ld_mode == LOAD_SER && !sen) |=> ($stable(ae_ofs) && $stable(af_ofs)));

  p_prs_keep_r6: assert property (@(posedge clk) disable iff (!mrs_n)
    !prs_n |=> ($stable(ae_ofs) && $stable(af_ofs)));

  p_wr_wins_r10: assert property (@(posedge clk) disable iff (!mrs_n)
    (ld_mode == LOAD_PAR && wr_en && rd_en) |=> $stable(rdata));
endmodule

bind flg_ofs_loader flg_ofs_loader_chk #(.OFS_W(OFS_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_flg_ofs_loader.sv
module sim_flg_ofs_loader;
  localparam int CLK_PERIOD = 10;
  localparam int OFS_W = 10;
  localparam int DEPTH = 2048;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NB    = 2 * OFS_W;

  logic clk = 1'b0;
  logic mrs_n, prs_n, ld, si, sen, wr_en, rd_en;
  logic [OFS_W-1:0] wdata;
  logic [CNT_W-1:0] count;
  logic pae_n, paf_n;
  logic [OFS_W-1:0] rdata;

  int n_chk = 0;
  int n_err = 0;

  // bench model of the required behaviour
  int m_ae, m_af, m_ptr, m_idx, m_rd;
  bit m_ser, m_pae, m_paf;

  always #(CLK_PERIOD/2) clk = ~clk;

  flg_ofs_loader #(.OFS_W(OFS_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .mrs_n(mrs_n), .prs_n(prs_n), .ld(ld), .si(si), .sen(sen),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .count(count),
    .pae_n(pae_n), .paf_n(paf_n), .rdata(rdata)
  );

  function automatic bit exp_pae(int c, int ae);
    return !(c <= ae);
  endfunction

  function automatic bit exp_paf(int c, int af);
    return !((DEPTH - c) <= af);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(string rreq);
    chk(pae_n == m_pae, "R7 pae_n", int'(pae_n), int'(m_pae));
    chk(paf_n == m_paf, "R8 paf_n", int'(paf_n), int'(m_paf));
    chk(int'(rdata) == m_rd, rreq, int'(rdata), m_rd);
  endtask

  // one clock: drive at negedge, update model at posedge, check at negedge
  task automatic cycle(bit p, bit w, bit r, bit s, bit sb, int wd, int c, string rreq);
    bit pw, pr, sl;
    prs_n = p; wr_en = w; rd_en = r; sen = s; si = sb;
    wdata = OFS_W'(wd); count = CNT_W'(c);
    @(posedge clk);
    if (!p) begin
      m_ptr = 0; m_idx = 0; m_pae = 1'b0; m_paf = 1'b1;
    end else begin
      m_pae = exp_pae(c, m_ae);
      m_paf = exp_paf(c, m_af);
      pw = w && !m_ser;
      pr = r && !pw;
      sl = s && m_ser;
      if (pw) begin
        if (m_ptr == 0) m_ae = wd; else m_af = wd;
        m_ptr ^= 1;
      end else if (pr) begin
        m_rd = (m_ptr == 0) ? m_ae : m_af;
        m_ptr ^= 1;
      end
      if (sl) begin
        if (m_idx < OFS_W) m_ae[m_idx] = sb;
        else               m_af[m_idx - OFS_W] = sb;
        m_idx = (m_idx == NB - 1) ? 0 : m_idx + 1;
      end
    end
    @(negedge clk);
    check_all(rreq);
  endtask

  task automatic master_reset(bit lv);
    mrs_n = 1'b0; ld = lv; prs_n = 1'b1; wr_en = 0; rd_en = 0; sen = 0; si = 0;
    repeat (2) @(negedge clk);
    chk(!pae_n && paf_n, "R9 flags in master reset", {pae_n, paf_n}, 1);
    chk(rdata == '0, "R9 rdata cleared", int'(rdata), 0);
    mrs_n = 1'b1;
    m_ser = lv; m_ae = lv ? 1023 : 127; m_af = m_ae;
    m_ptr = 0; m_idx = 0; m_rd = 0; m_pae = 0; m_paf = 1;
  endtask

  function automatic int pick_count();
    case ($urandom_range(0, 3))
      0: return $urandom_range(0, DEPTH);
      1: return (m_ae + int'($urandom_range(0, 2)) - 1 < 0) ? 0 : m_ae + int'($urandom_range(0, 2)) - 1;
      2: return (DEPTH - m_af + int'($urandom_range(0, 2)) - 1 > DEPTH) ? DEPTH
                : DEPTH - m_af + int'($urandom_range(0, 2)) - 1;
      default: return DEPTH - int'($urandom_range(0, 3));
    endcase
  endfunction

  task automatic random_run(int n, string rreq);
    for (int i = 0; i < n; i++)
      cycle($urandom_range(0, 19) != 0, $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
            $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
            int'($urandom_range(0, (1 << OFS_W) - 1)), pick_count(), rreq);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed = $urandom(1234);
    wdata = '0; count = '0;
    @(negedge clk);
    // parallel method
    master_reset(1'b0);
    cycle(1, 0, 1, 0, 0, 0, 0, "R1 default empty threshold");
    cycle(1, 0, 1, 0, 0, 0, 0, "R1 default full threshold");
    cycle(1, 1, 0, 0, 0, 40, 0, "R3 write empty threshold");
    cycle(1, 1, 0, 0, 0, 60, 0, "R3 write full threshold");
    cycle(1, 0, 1, 0, 0, 0, 40, "R3 read empty threshold");
    cycle(1, 0, 1, 0, 0, 0, 41, "R3 read full threshold");
    cycle(1, 0, 0, 0, 0, 0, DEPTH - 60, "R7 boundary");
    cycle(1, 0, 0, 0, 0, 0, DEPTH - 61, "R8 boundary");
    for (int i = 0; i < 25; i++) cycle(1, 0, 0, 1, 1, 0, 5, "R5 serial ignored");
    cycle(1, 0, 1, 0, 0, 0, 5, "R5 empty after serial try");
    cycle(1, 1, 1, 0, 0, 99, 5, "R10 write wins, rdata holds");
    cycle(1, 0, 1, 0, 0, 0, 5, "R10 empty threshold read");
    cycle(1, 0, 1, 0, 0, 0, 5, "R10 full threshold written");
    cycle(1, 1, 0, 0, 0, 300, 5, "R3 selector toggle");
    cycle(0, 1, 1, 0, 0, 7, 5, "R6 partial reset");
    cycle(1, 0, 1, 0, 0, 0, 5, "R6 selector back at empty");
    random_run(400, "R3 random parallel");
    // serial method
    master_reset(1'b1);
    cycle(1, 0, 1, 0, 0, 0, 0, "R2 default empty threshold");
    cycle(1, 0, 1, 0, 0, 0, 0, "R2 default full threshold");
    for (int i = 0; i < NB; i++)
      cycle(1, 0, 0, 1, (i % 3) == 0, 0, 100, "R4 serial shift");
    cycle(1, 0, 1, 0, 0, 0, 100, "R4 serial empty threshold");
    cycle(1, 0, 1, 0, 0, 0, 100, "R4 serial full threshold");
    cycle(1, 1, 0, 0, 0, 5, 100, "R5 parallel write ignored");
    cycle(1, 1, 0, 0, 0, 6, 100, "R5 parallel write ignored");
    cycle(0, 0, 0, 0, 0, 0, 100, "R6 partial reset serial");
    cycle(1, 0, 1, 0, 0, 0, 100, "R5 empty unchanged");
    cycle(1, 0, 1, 0, 0, 0, 100, "R5 full unchanged");
    for (int i = 0; i < 7; i++) cycle(1, 0, 0, 1, 1, 0, 100, "R4 partial load");
    cycle(0, 0, 0, 0, 0, 0, 100, "R6 partial reset restarts bits");
    for (int i = 0; i < 3; i++) cycle(1, 0, 0, 1, 0, 0, 100, "R6 bit position restart");
    cycle(1, 0, 1, 0, 0, 0, 100, "R6 empty threshold after restart");
    random_run(500, "R4 random serial");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule